// File: doc/BRIEF.md
# PCI Bus Target Controller

This block is a simplified 32-bit target for a PCI-style shared bus. The address/data lines and the command/byte-enable lines are time-multiplexed. When the bus is idle and the initiator pulls the transaction-start strobe low, the block captures the address and the 4-bit command from that clock. It sorts the command into memory read, memory write, I/O read, I/O write or "not ours". It then claims the access if the address falls inside its memory window or its I/O window. Both windows map onto the same small internal register file, one 32-bit word per 4-byte step.

After a claim, the block completes data phases with the two-signal ready handshake. It writes the register file under active-low byte enables, or drives register words back onto the bus, and it advances one word per completed phase. It also disconnects a burst that would run off the end of its window.

Every bidirectional bus line is modelled as an input, an output value and an output enable, so the block can sit behind ordinary pad logic. The three target control lines share one enable.

Top module: `pci_tgt_core`

## Requirements
- R1: While reset is high, and on the clock that follows it, the control-line enable and the AD-bus enable are both low. The register file resets to all zeros.
- R2: The following command codes are decoded:
  - 0110, 1100 and 1110 are memory reads.
  - 0111 and 1111 are memory writes.
  - 0010 is an I/O read and 0011 is an I/O write.
  
  Each of these is claimed when its address falls in the matching window.
- R3: The codes 0000, 0001, 1010, 1011 and every unlisted code (0100, 0101, 1000, 1001, 1101) are never claimed and leave the register file untouched. The block ignores the bus until the start strobe and the initiator-ready line are both high again.
- R4: The memory window starts at MEM_BASE and the I/O window at IO_BASE. Each window is NUM_REGS*4 bytes, aligned to its size. A memory command aimed at the I/O window, an I/O command aimed at the memory window, and any address outside both windows are not claimed. Inside either window, byte address bits [IDXW+1:2] select the same register word.
- R5: The claim line (active low) is first seen asserted at the second clock edge after the address edge (medium decode). Target-ready is never asserted while the claim line is not.
- R6: On a write, target-ready is asserted together with the claim. Each edge where target-ready and initiator-ready are both low stores the AD word. Byte b (bits 8b+7..8b) is stored only when byte-enable bit b is 0.
- R7: On a read, the clock in which the claim first appears is a turnaround clock: the AD bus is not driven and target-ready stays high. From the next clock, the AD bus carries the addressed word and target-ready is low.
- R8: A burst moves to the next register word after every completed data phase. Clocks with initiator-ready high are wait states that neither transfer nor advance.
- R9: A phase that completes while the start strobe is high is the last one. On the next clock, the claim, target-ready and stop lines are driven high and the AD bus is released. On the clock after that, the control-line enable is low.
- R10: While the current word is the last word of the window, stop is asserted with target-ready. If that phase completes with the start strobe still low, target-ready goes high while stop and claim stay low until the start strobe is high. The release of R9 then follows.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| adbus_i | input | 32 | Address/data bus as seen at the pads |
| adbus_o | output | 32 | Read data driven toward the bus |
| adbus_oe | output | 1 | Enable for adbus_o |
| cmd_be_n_i | input | 4 | Command on the address clock; active-low byte enables afterwards |
| bus_start_n_i | input | 1 | Transaction-start strobe from the initiator, active low |
| mst_rdy_n_i | input | 1 | Initiator ready, active low |
| ctl_oe | output | 1 | Shared enable for claim_n_o, tgt_rdy_n_o and halt_n_o |
| claim_n_o | output | 1 | Device-claim line, active low |
| tgt_rdy_n_o | output | 1 | Target ready, active low |
| halt_n_o | output | 1 | Stop request to the initiator, active low |

## Verification
The bench goes after several corner cases, each tied to a specific wrong behaviour:
- **Burst running into the last register word.** A design that does not disconnect there would wrap the index and overwrite word 0.
- **Single access to the last word.** A design that loses track of the disconnect would leave the stop line stuck.
- **Medium-decode and read-turnaround timing.** A claim one clock early, or AD drive in the turnaround clock, would collide with the initiator's address drive.
- **Commands and windows that must be refused.** These are reserved and configuration codes, memory commands aimed at the I/O window, and the first address past the window. A loose decoder would claim them and corrupt stored words.
- **Random initiator wait states and partial byte enables.** These are checked against a word model. A design that advances on wait states, or ignores the enables, returns shifted or merged data.

// File: rtl/pci_tgt_pkg.sv
package pci_tgt_pkg;

    typedef enum logic [2:0] {
        ACC_NONE,
        ACC_MEM_RD,
        ACC_MEM_WR,
        ACC_IO_RD,
        ACC_IO_WR
    } acc_kind_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DECODE,
        ST_TURN,
        ST_XFER,
        ST_DISC,
        ST_RELEASE,
        ST_SKIP
    } tgt_state_e;

    typedef struct packed {
        logic hit;
        logic write;
    } claim_info_t;

    function automatic acc_kind_e classify_cmd(input logic [3:0] code);
        acc_kind_e k;
        case (code)
            4'b0010:                   k = ACC_IO_RD;
            4'b0011:                   k = ACC_IO_WR;
            4'b0110, 4'b1100, 4'b1110: k = ACC_MEM_RD;
            4'b0111, 4'b1111:          k = ACC_MEM_WR;
            default:                   k = ACC_NONE;
        endcase
        return k;
    endfunction

    function automatic logic kind_writes(input acc_kind_e k);
        return (k == ACC_MEM_WR) || (k == ACC_IO_WR);
    endfunction

    function automatic logic kind_is_mem(input acc_kind_e k);
        return (k == ACC_MEM_RD) || (k == ACC_MEM_WR);
    endfunction

    function automatic logic [31:0] merge_bytes(input logic [31:0] old_w,
                                                input logic [31:0] new_w,
                                                input logic [3:0]  be_n);
        logic [31:0] r;
        r = old_w;
        for (int b = 0; b < 4; b++) begin
            if (!be_n[b]) r[8*b +: 8] = new_w[8*b +: 8];
        end
        return r;
    endfunction

endpackage

// File: rtl/pci_tgt_decode.sv
module pci_tgt_decode
    import pci_tgt_pkg::*;
#(
    parameter logic [31:0] MEM_BASE = 32'h4000_0000,
    parameter logic [31:0] IO_BASE  = 32'h0000_0C00,
    parameter int          IDXW     = 4
) (
    input  logic [31:2]     addr_w,
    input  logic [3:0]      code,
    output claim_info_t     info,
    output logic [IDXW-1:0] word_idx
);
    localparam int LSB = IDXW + 2;

    acc_kind_e kind;
    logic      mem_match;
    logic      io_match;

    always_comb begin
        kind       = classify_cmd(code);
        mem_match  = (addr_w[31:LSB] == MEM_BASE[31:LSB]);
        io_match   = (addr_w[31:LSB] == IO_BASE[31:LSB]);
        info.write = kind_writes(kind);
        if (kind == ACC_NONE)
            info.hit = 1'b0;
        else if (kind_is_mem(kind))
            info.hit = mem_match;
        else
            info.hit = io_match;
    end

    assign word_idx = addr_w[LSB-1:2];

endmodule

// File: rtl/pci_tgt_regfile.sv
module pci_tgt_regfile
    import pci_tgt_pkg::*;
#(
    parameter int NUM_REGS = 16,
    parameter int IDXW     = 4
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            wr_en,
    input  logic [IDXW-1:0] wr_idx,
    input  logic [31:0]     wr_data,
    input  logic [3:0]      wr_be_n,
    input  logic [IDXW-1:0] rd_idx,
    output logic [31:0]     rd_data
);
    logic [31:0] words [NUM_REGS];

    for (genvar w = 0; w < NUM_REGS; w++) begin : g_word
        always_ff @(posedge clk) begin
            if (rst)
                words[w] <= '0;
            else if (wr_en && (wr_idx == IDXW'(w)))
                words[w] <= merge_bytes(words[w], wr_data, wr_be_n);
        end
    end

    assign rd_data = words[rd_idx];

endmodule

// File: rtl/pci_tgt_seq.sv
module pci_tgt_seq
    import pci_tgt_pkg::*;
#(
    parameter int NUM_REGS = 16,
    parameter int IDXW     = 4
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            bus_start_n,
    input  logic            mst_rdy_n,
    input  claim_info_t     dec,
    input  logic [IDXW-1:0] start_idx,
    output tgt_state_e      state,
    output logic [IDXW-1:0] cur_idx,
    output logic            wr_mode,
    output logic            at_last,
    output logic            wr_en
);
    localparam logic [IDXW-1:0] LAST_IDX = IDXW'(NUM_REGS - 1);

    logic hit_q;

    assign at_last = (cur_idx == LAST_IDX);
    assign wr_en   = (state == ST_XFER) && !mst_rdy_n && wr_mode;

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            cur_idx <= '0;
            wr_mode <= 1'b0;
            hit_q   <= 1'b0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (!bus_start_n) begin
                        hit_q   <= dec.hit;
                        wr_mode <= dec.write;
                        cur_idx <= start_idx;
                        state   <= ST_DECODE;
                    end
                end
                ST_DECODE: begin
                    if (!hit_q)
                        state <= ST_SKIP;
                    else if (wr_mode)
                        state <= ST_XFER;
                    else
                        state <= ST_TURN;
                end
                ST_TURN: state <= ST_XFER;
                ST_XFER: begin
                    if (!mst_rdy_n) begin
                        cur_idx <= cur_idx + 1'b1;
                        if (bus_start_n)
                            state <= ST_RELEASE;
                        else if (at_last)
                            state <= ST_DISC;
                    end
                end
                ST_DISC: begin
                    if (bus_start_n) state <= ST_RELEASE;
                end
                ST_RELEASE: state <= ST_IDLE;
                ST_SKIP: begin
                    if (bus_start_n && mst_rdy_n) state <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/pci_tgt_core.sv
module pci_tgt_core
    import pci_tgt_pkg::*;
#(
    parameter logic [31:0] MEM_BASE = 32'h4000_0000,
    parameter logic [31:0] IO_BASE  = 32'h0000_0C00,
    parameter int          NUM_REGS = 16
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [31:0] adbus_i,
    output logic [31:0] adbus_o,
    output logic        adbus_oe,
    input  logic [3:0]  cmd_be_n_i,
    input  logic        bus_start_n_i,
    input  logic        mst_rdy_n_i,
    output logic        ctl_oe,
    output logic        claim_n_o,
    output logic        tgt_rdy_n_o,
    output logic        halt_n_o
);
    localparam int IDXW = $clog2(NUM_REGS);

    claim_info_t     dec_info;
    logic [IDXW-1:0] dec_idx;
    tgt_state_e      state;
    logic [IDXW-1:0] cur_idx;
    logic            wr_mode;
    logic            at_last;
    logic            wr_en;
    logic            st_idle;

    pci_tgt_decode #(
        .MEM_BASE (MEM_BASE),
        .IO_BASE  (IO_BASE),
        .IDXW     (IDXW)
    ) u_decode (
        .addr_w   (adbus_i[31:2]),
        .code     (cmd_be_n_i),
        .info     (dec_info),
        .word_idx (dec_idx)
    );

    pci_tgt_seq #(
        .NUM_REGS (NUM_REGS),
        .IDXW     (IDXW)
    ) u_seq (
        .clk         (clk),
        .rst         (rst),
        .bus_start_n (bus_start_n_i),
        .mst_rdy_n   (mst_rdy_n_i),
        .dec         (dec_info),
        .start_idx   (dec_idx),
        .state       (state),
        .cur_idx     (cur_idx),
        .wr_mode     (wr_mode),
        .at_last     (at_last),
        .wr_en       (wr_en)
    );

    pci_tgt_regfile #(
        .NUM_REGS (NUM_REGS),
        .IDXW     (IDXW)
    ) u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_idx  (cur_idx),
        .wr_data (adbus_i),
        .wr_be_n (cmd_be_n_i),
        .rd_idx  (cur_idx),
        .rd_data (adbus_o)
    );

    assign st_idle     = (state == ST_IDLE);
    assign ctl_oe      = (state == ST_TURN) || (state == ST_XFER) ||
                         (state == ST_DISC) || (state == ST_RELEASE);
    assign claim_n_o   = !((state == ST_TURN) || (state == ST_XFER) || (state == ST_DISC));
    assign tgt_rdy_n_o = (state != ST_XFER);
    assign halt_n_o    = !(((state == ST_XFER) && at_last) || (state == ST_DISC));
    assign adbus_oe    = (state == ST_XFER) && !wr_mode;

endmodule

// File: rtl/pci_tgt_core_chk.sv
module pci_tgt_core_chk
    import pci_tgt_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic [3:0] cmd_be_n_i,
    input logic       bus_start_n_i,
    input logic       mst_rdy_n_i,
    input logic       ctl_oe,
    input logic       claim_n_o,
    input logic       tgt_rdy_n_o,
    input logic       halt_n_o,
    input logic       adbus_oe,
    input logic       st_idle
);
    logic rst_q;

    always_ff @(posedge clk) begin
        rst_q <= rst;
    end

    always @(posedge clk) begin
        if (rst_q === 1'b1) begin
            AST_RESET_RELEASED: assert (!ctl_oe && !adbus_oe) else $error("drivers enabled after reset"); // R1
        end
    end

    AST_TRDY_NEEDS_CLAIM: assert property (@(posedge clk) disable iff (rst)
        (ctl_oe && !tgt_rdy_n_o) |-> !claim_n_o); // R5

    AST_MEDIUM_DECODE: assert property (@(posedge clk) disable iff (rst)
        (ctl_oe && $fell(claim_n_o)) |-> $past(st_idle && !bus_start_n_i, 2)); // R5

    AST_NO_CLAIM_UNSUPPORTED: assert property (@(posedge clk) disable iff (rst)
        (st_idle && !bus_start_n_i && (classify_cmd(cmd_be_n_i) == ACC_NONE))
        |=> ##1 claim_n_o); // R3

    AST_READ_TURNAROUND: assert property (@(posedge clk) disable iff (rst)
        $rose(adbus_oe) |-> $past(ctl_oe && !claim_n_o && tgt_rdy_n_o)); // R7

    AST_LAST_PHASE_RELEASE: assert property (@(posedge clk) disable iff (rst)
        (ctl_oe && !tgt_rdy_n_o && !mst_rdy_n_i && bus_start_n_i)
        |=> (ctl_oe && claim_n_o && tgt_rdy_n_o && halt_n_o && !adbus_oe) ##1 !ctl_oe); // R9

    AST_DISCONNECT_HOLD: assert property (@(posedge clk) disable iff (rst)
        (ctl_oe && !tgt_rdy_n_o && !halt_n_o && !mst_rdy_n_i && !bus_start_n_i)
        |=> (!claim_n_o && !halt_n_o && tgt_rdy_n_o && !adbus_oe)); // R10

    AST_STOP_NEEDS_CLAIM: assert property (@(posedge clk) disable iff (rst)
        (ctl_oe && !halt_n_o) |-> !claim_n_o); // R10

endmodule

bind pci_tgt_core pci_tgt_core_chk u_chk (
    .clk           (clk),
    .rst           (rst),
    .cmd_be_n_i    (cmd_be_n_i),
    .bus_start_n_i (bus_start_n_i),
    .mst_rdy_n_i   (mst_rdy_n_i),
    .ctl_oe        (ctl_oe),
    .claim_n_o     (claim_n_o),
    .tgt_rdy_n_o   (tgt_rdy_n_o),
    .halt_n_o      (halt_n_o),
    .adbus_oe      (adbus_oe),
    .st_idle       (st_idle)
);

// File: tb/pci_tgt_core_tb.sv
module pci_tgt_core_tb;
    localparam int          NR = 16;
    localparam logic [31:0] MB = 32'h4000_0000;
    localparam logic [31:0] IB = 32'h0000_0C00;

    logic        clk = 1'b0;
    logic        rst;
    logic [31:0] ad_in;
    logic [3:0]  cbe_n;
    logic        frame_n, irdy_n;
    logic [31:0] ad_o;
    logic        ad_oe, ctl_oe, claim_n, trdy_n, halt_n;

    int n_chk = 0;
    int n_bad = 0;
    bit all_done = 1'b0;

    logic [31:0] wdat [8];
    logic [3:0]  wbe  [8];
    logic [31:0] rdat [8];
    logic [31:0] model [NR];

    int r_done, r_claim_cyc, r_trdy_cyc, r_adoe_cyc;
    bit r_claimed, r_stopped, r_relok, r_discok;

    always #4 clk = ~clk;

    pci_tgt_core #(.MEM_BASE(MB), .IO_BASE(IB), .NUM_REGS(NR)) u_dut (
        .clk(clk), .rst(rst), .adbus_i(ad_in), .adbus_o(ad_o), .adbus_oe(ad_oe),
        .cmd_be_n_i(cbe_n), .bus_start_n_i(frame_n), .mst_rdy_n_i(irdy_n),
        .ctl_oe(ctl_oe), .claim_n_o(claim_n), .tgt_rdy_n_o(trdy_n), .halt_n_o(halt_n)
    );

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic int exp_kind(input logic [3:0] c);
        case (c)
            4'h6, 4'hC, 4'hE: return 1;
            4'h7, 4'hF:       return 2;
            4'h2:             return 3;
            4'h3:             return 4;
            default:          return 0;
        endcase
    endfunction

    function automatic logic [31:0] apply_be(input logic [31:0] o, input logic [31:0] d, input logic [3:0] be_n);
        logic [31:0] r = o;
        for (int b = 0; b < 4; b++) if (!be_n[b]) r[8*b +: 8] = d[8*b +: 8];
        return r;
    endfunction

    task automatic master(input logic [3:0] cmd, input logic [31:0] addr, input int n,
                          input bit wr, input int wait_pct);
        bit ir = 1'b0;
        bit fin = 1'b0;
        r_done = 0; r_claimed = 0; r_stopped = 0; r_relok = 1; r_discok = 1;
        r_claim_cyc = -1; r_trdy_cyc = -1; r_adoe_cyc = -1;
        @(negedge clk);
        frame_n = 1'b0; irdy_n = 1'b1; ad_in = addr; cbe_n = cmd;
        for (int cyc = 0; cyc < 80 && !fin; cyc++) begin
            @(negedge clk);
            if (!ir) ir = ($urandom_range(99) >= wait_pct);
            irdy_n  = !ir;
            frame_n = ir && (r_done == n - 1);
            ad_in   = wr ? wdat[r_done] : 32'hA5A5_5A5A;
            cbe_n   = wr ? wbe[r_done] : 4'h0;
            if (ctl_oe && !claim_n && r_claim_cyc < 0) r_claim_cyc = cyc;
            if (ctl_oe && !trdy_n && r_trdy_cyc < 0)   r_trdy_cyc = cyc;
            if (ad_oe && r_adoe_cyc < 0)               r_adoe_cyc = cyc;
            if (ctl_oe && !claim_n)                    r_claimed = 1'b1;
            if (!r_claimed && cyc == 4) begin
                frame_n = 1'b1; irdy_n = 1'b0;
                @(negedge clk);
                irdy_n = 1'b1;
                fin = 1'b1;
            end else if (ir && ctl_oe && !trdy_n) begin
                if (!wr) rdat[r_done] = ad_o;
                if (!halt_n) r_stopped = 1'b1;
                r_done++;
                ir = 1'b0;
                if (frame_n) begin
                    @(negedge clk);
                    frame_n = 1'b1; irdy_n = 1'b1;
                    r_relok = ctl_oe && claim_n && trdy_n && halt_n && !ad_oe;
                    @(negedge clk);
                    r_relok = r_relok && !ctl_oe;
                    fin = 1'b1;
                end else if (!halt_n) begin
                    @(negedge clk);
                    frame_n = 1'b1; irdy_n = 1'b0;
                    r_discok = ctl_oe && !claim_n && !halt_n && trdy_n;
                    @(negedge clk);
                    irdy_n = 1'b1;
                    r_relok = ctl_oe && claim_n && trdy_n && halt_n && !ad_oe;
                    @(negedge clk);
                    r_relok = r_relok && !ctl_oe;
                    fin = 1'b1;
                end
            end
        end
        frame_n = 1'b1; irdy_n = 1'b1;
    endtask

    task automatic do_xact(input logic [3:0] cmd, input logic [31:0] addr, input int n, input int wp);
        int          kind = exp_kind(cmd);
        bit          is_mem = (kind == 1) || (kind == 2);
        bit          wr = (kind == 0) ? cmd[0] : ((kind == 2) || (kind == 4));
        logic [31:0] base = is_mem ? MB : IB;
        bit          hit = (kind != 0) && (addr >= base) && (addr < base + NR * 4);
        int          idx0 = hit ? int'((addr - base) >> 2) : 0;
        int          exp_done = hit ? ((n < NR - idx0) ? n : NR - idx0) : 0;
        string       tag = hit ? "R2" : ((kind == 0) ? "R3" : "R4");
        master(cmd, addr, n, wr, wp);
        chk(tag, "claimed", 32'(r_claimed), 32'(hit));
        chk((exp_done < n) ? "R10" : "R8", "phases done", 32'(r_done), 32'(exp_done));
        if (hit) begin
            chk("R5", "claim cycle", 32'(r_claim_cyc), 32'd1);
            chk(wr ? "R6" : "R7", "first ready cycle", 32'(r_trdy_cyc), wr ? 32'd1 : 32'd2);
            if (!wr) chk("R7", "first AD drive cycle", 32'(r_adoe_cyc), 32'd2);
            chk("R10", "stop at last word", 32'(r_stopped), 32'(idx0 + exp_done - 1 == NR - 1));
            chk("R9", "release sequence", 32'(r_relok), 32'd1);
            if (exp_done < n) chk("R10", "disconnect hold", 32'(r_discok), 32'd1);
        end else begin
            chk(tag, "claim cycle none", 32'(r_claim_cyc), 32'hFFFF_FFFF);
        end
        if (hit && wr) begin
            for (int j = 0; j < r_done && idx0 + j < NR; j++)
                model[idx0 + j] = apply_be(model[idx0 + j], wdat[j], wbe[j]);
        end
        if (hit && !wr) begin
            for (int j = 0; j < r_done && idx0 + j < NR; j++)
                chk("R8", "read word", rdat[j], model[idx0 + j]);
        end
        @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!all_done) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk + 1, n_bad);
            $finish;
        end
    end

    initial begin
        logic [3:0]  c;
        logic [31:0] a;
        int          ri, nn, region;
        void'($urandom(32'd20240611));
        for (int i = 0; i < NR; i++) model[i] = '0;
        rst = 1'b1; frame_n = 1'b1; irdy_n = 1'b1; ad_in = '0; cbe_n = 4'hF;
        repeat (3) @(negedge clk);
        chk("R1", "ctl enable in reset", 32'(ctl_oe), 32'd0);
        chk("R1", "AD enable in reset", 32'(ad_oe), 32'd0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1", "ctl enable after reset", 32'(ctl_oe), 32'd0);

        // R1 R7: read of word 0 after reset returns zero
        do_xact(4'h6, MB, 1, 0);
        // R6 R8: four-word memory write burst with waits
        for (int j = 0; j < 4; j++) begin wdat[j] = 32'h1111_0000 + j; wbe[j] = 4'h0; end
        do_xact(4'h7, MB, 4, 30);
        // R4 R8: read back through the I/O window alias
        do_xact(4'h2, IB, 4, 30);
        // R6: write-and-invalidate with partial byte enables
        wdat[0] = 32'hAABB_CCDD; wbe[0] = 4'b1010;
        do_xact(4'hF, MB + 5 * 4, 1, 0);
        do_xact(4'hE, MB + 5 * 4, 1, 0);
        // R4: I/O write, memory read back
        wdat[0] = 32'hCAFE_F00D; wbe[0] = 4'h0;
        do_xact(4'h3, IB + 7 * 4, 1, 0);
        do_xact(4'h6, MB + 7 * 4, 1, 0);
        // R10: burst running off the end of the window
        for (int j = 0; j < 4; j++) begin wdat[j] = 32'h7700_0000 + j; wbe[j] = 4'h0; end
        do_xact(4'h7, MB + (NR - 2) * 4, 4, 0);
        do_xact(4'hC, MB + (NR - 1) * 4, 1, 0);
        do_xact(4'h6, MB + (NR - 2) * 4, 3, 20);
        // R3: reserved and configuration codes are refused and store nothing
        wdat[0] = 32'hDEAD_DEAD; wbe[0] = 4'h0;
        do_xact(4'h5, MB, 1, 0);
        do_xact(4'hB, MB, 1, 0);
        do_xact(4'h1, MB, 1, 0);
        do_xact(4'h6, MB, 1, 0);
        // R4: wrong window type and first address past the window
        do_xact(4'h7, IB, 1, 0);
        do_xact(4'h3, MB, 1, 0);
        do_xact(4'h7, MB + NR * 4, 1, 0);

        for (int t = 0; t < 80; t++) begin
            c = 4'($urandom_range(15));
            ri = $urandom_range(NR - 1);
            nn = 1 + $urandom_range(4);
            region = $urandom_range(3);
            case (region)
                0:       a = MB + 32'(ri * 4);
                1:       a = IB + 32'(ri * 4);
                2:       a = MB + NR * 4 + 32'(ri * 4);
                default: a = $urandom() & 32'hFFFF_FFFC;
            endcase
            for (int j = 0; j < 8; j++) begin
                wdat[j] = $urandom();
                wbe[j] = 4'($urandom_range(15));
            end
            do_xact(c, a, nn, $urandom_range(40));
        end
        for (int i = 0; i < NR; i += 4) do_xact(4'h6, MB + 32'(i * 4), 4, 10);

        all_done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule